// File: doc/BRIEF.md
# Scaled Pixel Multiplier

This block multiplies two image streams sample by sample and scales each product by a fraction between zero and one. The two sources deliver co-located pixels on separate valid/ready streams. A beat is taken only when both streams offer data, and the two beats are consumed together. Each colour component is handled on its own. The result leaves on a third valid/ready stream together with the line and frame markers of the first source.

Parameters fix the format at elaboration. A component is either an unsigned 8-bit value or a signed 16-bit value, and a pixel has one or three components. A beat carries one pixel or eight pixels. The overflow handling is also fixed at elaboration: the result either wraps to the output width or clamps to the range of the output type. The scale is an unsigned fixed-point value that can change on any beat. It applies to the beat it is accepted with.

The datapath has three register stages that share one enable, so a stalled output freezes the whole pipeline. The design holds no frame or line storage.

Top module: `pixmul_scaled`

## Requirements
- R1: For each component, the output is the input-A value times the input-B value times the scale, rounded to nearest. The scale `scale_i` is unsigned with 15 fractional bits, so 0x8000 means 1.0 and 0x4000 means 0.5. Rounding adds 2^14 to the full product and then shifts right arithmetically by 15, so an exact half rounds toward plus infinity (1.5 gives 2, and -1.5 gives -1). A scale of 0 gives 0.
- R2: Any scale value above 0x8000 is treated as exactly 0x8000.
- R3: With SATURATE=1, a rounded result outside the output range is clamped to that range. The range is 0..255 for unsigned 8-bit and -32768..32767 for signed 16-bit.
- R4: With SATURATE=0, the output is the low component-width bits of the rounded result in two's complement. For example, 255 x 255 at scale 1.0 gives 1 in 8-bit.
- R5: SIGNED_FMT=0 selects unsigned 8-bit components and SIGNED_FMT=1 selects signed 16-bit components. CHANNELS is 1 or 3. Inputs and output share the format, and channels never interact.
- R6: LANES is 1 or 8 pixels per beat. Component c of pixel l occupies bits [(l*CHANNELS+c)*CW +: CW] of a data bus, where CW is 8 or 16. Every lane is computed independently. In 8-lane use, the line width must be a multiple of 8.
- R7: A beat is accepted only in a cycle where both `a_valid_i` and `b_valid_i` are high and the pipeline can advance. Both streams are consumed in that same cycle. A valid on only one stream is never accepted and produces no output.
- R8: With `out_ready_i` held high, a beat accepted in cycle n appears with `out_valid_o` high in cycle n+3.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the output data and markers hold, no input is accepted, and every beat already in flight later comes out in order with none lost.
- R10: `out_eol_o` and `out_eof_o` carry the `a_eol_i` and `a_eof_i` values of the beat whose data they accompany.
- R11: While `rst_n` is low, `out_valid_o`, `a_ready_o` and `b_ready_o` are low, even if both input valids are high.
- R12: The scale is sampled with each accepted beat, so back-to-back beats carrying different scales each use their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scale_i | input | 16 | Unsigned scale with 15 fractional bits, sampled with each accepted beat |
| a_valid_i | input | 1 | Source A beat valid |
| a_ready_o | output | 1 | Source A beat taken |
| a_data_i | input | LANES*CHANNELS*CW | Source A packed components |
| a_eol_i | input | 1 | Source A end-of-line marker |
| a_eof_i | input | 1 | Source A end-of-frame marker |
| b_valid_i | input | 1 | Source B beat valid |
| b_ready_o | output | 1 | Source B beat taken |
| b_data_i | input | LANES*CHANNELS*CW | Source B packed components |
| out_valid_o | output | 1 | Result beat valid |
| out_ready_i | input | 1 | Downstream accepts result beat |
| out_data_o | output | LANES*CHANNELS*CW | Packed result components |
| out_eol_o | output | 1 | End-of-line marker aligned with the result |
| out_eof_o | output | 1 | End-of-frame marker aligned with the result |

## Verification
The bound properties cover the stream rules on every cycle. They check that both sources are consumed together and that nothing is accepted while the output is stalled. They also check that a stalled result beat holds its data and markers, and that a beat reaches the output exactly three cycles after acceptance when the output is never stalled. The arithmetic needs the bench's scenarios, which compare against values computed from the formula. These cover rounding of exact halves, scale values of zero and above one, clamping at both ends of the signed and unsigned ranges, wrapping, and per-lane and per-channel independence. The scenarios also show the in-order drain after a long stall, the line and frame markers, per-beat scale sampling, and one-sided valids that must not produce output.

// File: rtl/pixmul_pkg.sv
package pixmul_pkg;
  // scale encoding: unsigned, SCALE_FRAC fractional bits
  localparam int SCALE_W    = 16;
  localparam int SCALE_FRAC = 15;
  localparam logic [SCALE_W-1:0] SCALE_ONE = 16'h8000;

  // register stages between acceptance and output
  localparam int PIPE_LAT = 3;

  typedef struct packed {
    logic eol;
    logic eof;
  } side_t;
endpackage

// File: rtl/pixmul_ctrl.sv
module pixmul_ctrl
  import pixmul_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  a_valid_i,
  input  logic  b_valid_i,
  input  side_t a_side_i,
  input  logic  out_ready_i,
  output logic  a_ready_o,
  output logic  b_ready_o,
  output logic  adv_o,
  output logic  rst_n_int_o,
  output logic  out_valid_o,
  output side_t out_side_o
);
  // reset synchronizer: asserts at once, releases after two edges
  logic [1:0] rsync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_int   = rsync_q[1];
  assign rst_n_int_o = rst_n_int;

  logic [PIPE_LAT-1:0] vld_q, vld_d;
  side_t               side_q [PIPE_LAT];
  side_t               side_d [PIPE_LAT];
  logic                adv, fire;

  always_comb begin
    adv       = !vld_q[PIPE_LAT-1] || out_ready_i;
    fire      = a_valid_i && b_valid_i && adv && rst_n_int;
    a_ready_o = adv && b_valid_i && rst_n_int;
    b_ready_o = adv && a_valid_i && rst_n_int;
    vld_d     = {vld_q[PIPE_LAT-2:0], fire};
    side_d[0] = a_side_i;
    for (int k = 1; k < PIPE_LAT; k++) side_d[k] = side_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      vld_q <= '0;
      for (int k = 0; k < PIPE_LAT; k++) side_q[k] <= '0;
    end else if (adv) begin
      vld_q <= vld_d;
      for (int k = 0; k < PIPE_LAT; k++) side_q[k] <= side_d[k];
    end
  end

  assign adv_o       = adv;
  assign out_valid_o = vld_q[PIPE_LAT-1];
  assign out_side_o  = side_q[PIPE_LAT-1];
endmodule

// File: rtl/pixmul_comp.sv
module pixmul_comp
  import pixmul_pkg::*;
#(
  parameter int CW         = 8,
  parameter bit SIGNED_FMT = 1'b0,
  parameter bit SATURATE   = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [CW-1:0]      a_i,
  input  logic [CW-1:0]      b_i,
  input  logic [SCALE_W-1:0] scale_q_i,
  output logic [CW-1:0]      y_o
);
  localparam int EW = CW + 1;                 // operand with sign room
  localparam int PW = 2 * EW;                 // full product
  localparam int SW = PW + SCALE_W + 1;       // product times signed scale
  localparam int KW = SATURATE ? SW : CW;     // bits kept after rounding
  localparam logic signed [SW-1:0] ROUND = SW'(1) <<< (SCALE_FRAC - 1);

  logic signed [EW-1:0] a_ext, b_ext;
  logic signed [PW-1:0] prod_d, prod_q;
  logic signed [SW-1:0] scl_ext;
  logic signed [KW-1:0] keep_d, keep_q;
  logic        [CW-1:0] y_d;

  // stage 1: widen both operands, form the exact product
  always_comb begin
    a_ext  = SIGNED_FMT ? $signed({a_i[CW-1], a_i}) : $signed({1'b0, a_i});
    b_ext  = SIGNED_FMT ? $signed({b_i[CW-1], b_i}) : $signed({1'b0, b_i});
    prod_d = PW'(a_ext) * PW'(b_ext);
  end

  // stage 2: scale, add half an LSB, drop the fraction
  always_comb begin
    scl_ext = SW'($signed({1'b0, scale_q_i}));
    keep_d  = KW'(((SW'(prod_q) * scl_ext) + ROUND) >>> SCALE_FRAC);
  end

  // stage 3: overflow policy
  generate
    if (SATURATE) begin : g_clamp
      localparam logic signed [SW-1:0] HI = SIGNED_FMT ?
        SW'((64'sd1 <<< (CW - 1)) - 64'sd1) : SW'((64'sd1 <<< CW) - 64'sd1);
      localparam logic signed [SW-1:0] LO = SIGNED_FMT ?
        SW'(-(64'sd1 <<< (CW - 1))) : SW'(0);
      always_comb begin
        if (keep_q > HI)      y_d = HI[CW-1:0];
        else if (keep_q < LO) y_d = LO[CW-1:0];
        else                  y_d = keep_q[CW-1:0];
      end
    end else begin : g_wrap
      always_comb y_d = keep_q[CW-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      keep_q <= '0;
      y_o    <= '0;
    end else if (en) begin
      prod_q <= prod_d;
      keep_q <= keep_d;
      y_o    <= y_d;
    end
  end
endmodule

// File: rtl/pixmul_scaled.sv
module pixmul_scaled
  import pixmul_pkg::*;
#(
  parameter int LANES      = 1,
  parameter int CHANNELS   = 1,
  parameter bit SIGNED_FMT = 1'b0,
  parameter bit SATURATE   = 1'b1
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic [15:0]                                     scale_i,
  input  logic                                            a_valid_i,
  output logic                                            a_ready_o,
  input  logic [LANES*CHANNELS*(SIGNED_FMT ? 16 : 8)-1:0] a_data_i,
  input  logic                                            a_eol_i,
  input  logic                                            a_eof_i,
  input  logic                                            b_valid_i,
  output logic                                            b_ready_o,
  input  logic [LANES*CHANNELS*(SIGNED_FMT ? 16 : 8)-1:0] b_data_i,
  output logic                                            out_valid_o,
  input  logic                                            out_ready_i,
  output logic [LANES*CHANNELS*(SIGNED_FMT ? 16 : 8)-1:0] out_data_o,
  output logic                                            out_eol_o,
  output logic                                            out_eof_o
);
  localparam int CW    = SIGNED_FMT ? 16 : 8;
  localparam int NCOMP = LANES * CHANNELS;
  localparam int BW    = NCOMP * CW;

  side_t              a_side, out_side;
  logic               adv, rst_n_int;
  logic [SCALE_W-1:0] scale_cap, scale_q;

  assign a_side = '{eol: a_eol_i, eof: a_eof_i};

  // limit the scale to 1.0, register it alongside the stage-1 products
  always_comb scale_cap = (scale_i > SCALE_ONE) ? SCALE_ONE : scale_i;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  scale_q <= '0;
    else if (adv)    scale_q <= scale_cap;
  end

  pixmul_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .a_valid_i   (a_valid_i),
    .b_valid_i   (b_valid_i),
    .a_side_i    (a_side),
    .out_ready_i (out_ready_i),
    .a_ready_o   (a_ready_o),
    .b_ready_o   (b_ready_o),
    .adv_o       (adv),
    .rst_n_int_o (rst_n_int),
    .out_valid_o (out_valid_o),
    .out_side_o  (out_side)
  );

  generate
    for (genvar i = 0; i < NCOMP; i++) begin : g_comp
      pixmul_comp #(
        .CW         (CW),
        .SIGNED_FMT (SIGNED_FMT),
        .SATURATE   (SATURATE)
      ) u_comp (
        .clk       (clk),
        .rst_n     (rst_n_int),
        .en        (adv),
        .a_i       (a_data_i[i*CW +: CW]),
        .b_i       (b_data_i[i*CW +: CW]),
        .scale_q_i (scale_q),
        .y_o       (out_data_o[i*CW +: CW])
      );
    end
  endgenerate

  assign out_eol_o = out_side.eol;
  assign out_eof_o = out_side.eof;

  logic unused_bw;
  assign unused_bw = (BW == 0);
endmodule

// File: rtl/pixmul_scaled_chk.sv
module pixmul_scaled_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_valid_i,
  input logic          a_ready_o,
  input logic          b_valid_i,
  input logic          b_ready_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [DW-1:0] out_data_o,
  input logic          out_eol_o,
  input logic          out_eof_o
);
  // R7: source A taken implies source B taken in the same cycle
  p_pair_ab_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid_i && a_ready_o) |-> (b_valid_i && b_ready_o));

  // R7: and the other way round
  p_pair_ba_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid_i && b_ready_o) |-> (a_valid_i && a_ready_o));

  // R9: stalled output holds data and markers
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_eol_o) && $stable(out_eof_o)));

  // R9: nothing enters while the output is stalled
  p_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |-> (!a_ready_o && !b_ready_o));

  // R8: an accepted beat appears three cycles later when never stalled
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(a_valid_i && a_ready_o && b_valid_i, 3) && $past(out_ready_i, 2) && $past(out_ready_i, 1))
      |-> out_valid_o);
endmodule

bind pixmul_scaled pixmul_scaled_chk #(.DW(BW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .a_valid_i   (a_valid_i),
  .a_ready_o   (a_ready_o),
  .b_valid_i   (b_valid_i),
  .b_ready_o   (b_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_eol_o   (out_eol_o),
  .out_eof_o   (out_eof_o)
);

// File: tb/pixmul_scaled_tb.sv
`timescale 1ns/1ps
module pixmul_scaled_tb;
  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  // u_dut: 1 lane, 1 channel, unsigned 8-bit, clamp
  logic [15:0] d_scale;
  logic d_a_v, d_a_r, d_a_eol, d_a_eof, d_b_v, d_b_r, d_o_v, d_o_r, d_o_eol, d_o_eof;
  logic [7:0] d_a_d, d_b_d, d_o_d;
  // u_wrp: 8 lanes, 1 channel, unsigned 8-bit, wrap
  logic [15:0] w_scale;
  logic w_a_v, w_a_r, w_b_v, w_b_r, w_o_v, w_o_r, w_o_eol, w_o_eof;
  logic [63:0] w_a_d, w_b_d, w_o_d;
  // u_s16: 1 lane, 3 channels, signed 16-bit, clamp
  logic [15:0] s_scale;
  logic s_a_v, s_a_r, s_b_v, s_b_r, s_o_v, s_o_r, s_o_eol, s_o_eof;
  logic [47:0] s_a_d, s_b_d, s_o_d;

  pixmul_scaled #(.LANES(1), .CHANNELS(1), .SIGNED_FMT(1'b0), .SATURATE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .scale_i(d_scale),
    .a_valid_i(d_a_v), .a_ready_o(d_a_r), .a_data_i(d_a_d), .a_eol_i(d_a_eol), .a_eof_i(d_a_eof),
    .b_valid_i(d_b_v), .b_ready_o(d_b_r), .b_data_i(d_b_d),
    .out_valid_o(d_o_v), .out_ready_i(d_o_r), .out_data_o(d_o_d),
    .out_eol_o(d_o_eol), .out_eof_o(d_o_eof));

  pixmul_scaled #(.LANES(8), .CHANNELS(1), .SIGNED_FMT(1'b0), .SATURATE(1'b0)) u_wrp (
    .clk(clk), .rst_n(rst_n), .scale_i(w_scale),
    .a_valid_i(w_a_v), .a_ready_o(w_a_r), .a_data_i(w_a_d), .a_eol_i(1'b0), .a_eof_i(1'b0),
    .b_valid_i(w_b_v), .b_ready_o(w_b_r), .b_data_i(w_b_d),
    .out_valid_o(w_o_v), .out_ready_i(w_o_r), .out_data_o(w_o_d),
    .out_eol_o(w_o_eol), .out_eof_o(w_o_eof));

  pixmul_scaled #(.LANES(1), .CHANNELS(3), .SIGNED_FMT(1'b1), .SATURATE(1'b1)) u_s16 (
    .clk(clk), .rst_n(rst_n), .scale_i(s_scale),
    .a_valid_i(s_a_v), .a_ready_o(s_a_r), .a_data_i(s_a_d), .a_eol_i(1'b0), .a_eof_i(1'b0),
    .b_valid_i(s_b_v), .b_ready_o(s_b_r), .b_data_i(s_b_d),
    .out_valid_o(s_o_v), .out_ready_i(s_o_r), .out_data_o(s_o_d),
    .out_eol_o(s_o_eol), .out_eof_o(s_o_eof));

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // reference from the requirements (R1..R4)
  function automatic longint exp_c(longint a, longint b, longint s, bit sgn, bit sat);
    longint sc, r;
    sc = (s > 32768) ? 32768 : s;
    r  = (a * b * sc + 16384) >>> 15;
    if (sat) begin
      if (sgn) begin
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
      end else begin
        if (r > 255) r = 255;
        if (r < 0) r = 0;
      end
    end else begin
      r = sgn ? longint'($signed(r[15:0])) : (r & 255);
    end
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      n_fail++;
      $display("FAIL R7 watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic t_reset();
    rst_n = 1'b1;
    d_scale = 16'h8000; w_scale = 16'h8000; s_scale = 16'h8000;
    d_a_d = '0; d_b_d = '0; d_a_eol = 0; d_a_eof = 0; w_a_d = '0; w_b_d = '0; s_a_d = '0; s_b_d = '0;
    d_a_v = 1; d_b_v = 1; w_a_v = 1; w_b_v = 1; s_a_v = 1; s_b_v = 1;
    d_o_r = 1; w_o_r = 1; s_o_r = 1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!d_a_r && !d_b_r, "R11 readies low in reset", d_a_r, 0);
    chk(!w_a_r && !w_b_r && !s_a_r && !s_b_r, "R11 readies low in reset (wide)", w_a_r, 0);
    chk(!d_o_v && !w_o_v && !s_o_v, "R11 out_valid low in reset", d_o_v, 0);
    d_a_v = 0; d_b_v = 0; w_a_v = 0; w_b_v = 0; s_a_v = 0; s_b_v = 0;
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!d_o_v, "R11 idle after reset", d_o_v, 0);
  endtask

  task automatic d_beat(input int a, input int b, input int s, input bit eol, input bit eof, input string rq);
    int lat;
    longint e;
    d_a_d = 8'(a); d_b_d = 8'(b); d_scale = 16'(s); d_a_eol = eol; d_a_eof = eof;
    d_a_v = 1; d_b_v = 1;
    #1 chk(d_a_r && d_b_r, "R7 both ready", d_a_r, 1);
    @(posedge clk);
    @(negedge clk);
    d_a_v = 0; d_b_v = 0;
    lat = 1;
    while (!d_o_v && lat < 8) begin @(negedge clk); lat++; end
    chk(lat == 3, "R8 latency", lat, 3);
    e = exp_c(a, b, s, 1'b0, 1'b1);
    chk(longint'(d_o_d) == e, rq, longint'(d_o_d), e);
    chk(d_o_eol == eol && d_o_eof == eof, "R10 markers follow beat", {d_o_eol, d_o_eof}, {eol, eof});
    @(negedge clk);
    chk(!d_o_v, "R7 one output per beat", d_o_v, 0);
  endtask

  task automatic t_arith_u8();
    d_beat(10, 7, 16'h4000, 1'b0, 1'b0, "R1 scale 0.5");
    d_beat(3, 1, 16'h4000, 1'b1, 1'b0, "R1 half rounds up");
    d_beat(200, 100, 16'h0100, 1'b0, 1'b1, "R1 small scale");
    d_beat(90, 200, 16'h0000, 1'b1, 1'b1, "R1 zero scale");
    d_beat(255, 255, 16'h8000, 1'b0, 1'b0, "R3 clamp u8 high");
    d_beat(10, 10, 16'hFFFF, 1'b0, 1'b0, "R2 scale FFFF as one");
    d_beat(12, 11, 16'h8001, 1'b0, 1'b0, "R2 scale 8001 as one");
  endtask

  task automatic t_scale_per_beat();
    d_a_d = 16; d_b_d = 16; d_scale = 16'h8000; d_a_v = 1; d_b_v = 1;
    @(posedge clk);
    @(negedge clk);
    d_scale = 16'h2000;
    @(posedge clk);
    @(negedge clk);
    d_a_v = 0; d_b_v = 0;
    @(negedge clk);
    chk(d_o_v && d_o_d == 8'd255, "R12 first beat own scale", d_o_d, 255);
    @(negedge clk);
    chk(d_o_v && d_o_d == 8'd64, "R12 second beat own scale", d_o_d, 64);
    @(negedge clk);
  endtask

  task automatic t_one_sided();
    d_a_d = 50; d_b_d = 50; d_scale = 16'h8000;
    d_a_v = 1; d_b_v = 0;
    repeat (4) begin
      #1 chk(!d_a_r, "R7 lone A not taken", d_a_r, 0);
      chk(!d_o_v, "R7 no output from lone A", d_o_v, 0);
      @(negedge clk);
    end
    d_a_v = 0; d_b_v = 1;
    repeat (4) begin
      #1 chk(!d_b_r, "R7 lone B not taken", d_b_r, 0);
      chk(!d_o_v, "R7 no output from lone B", d_o_v, 0);
      @(negedge clk);
    end
    d_b_v = 0;
    repeat (3) @(negedge clk);
    chk(!d_o_v, "R7 still idle", d_o_v, 0);
    d_beat(5, 6, 16'h8000, 1'b0, 1'b0, "R7 paired beat after lone ones");
  endtask

  task automatic t_stall();
    int av [4] = '{2, 4, 6, 8};
    int bv [4] = '{3, 5, 7, 9};
    int ex [4] = '{6, 20, 42, 72};
    d_o_r = 0; d_scale = 16'h8000;
    for (int i = 0; i < 3; i++) begin
      d_a_d = 8'(av[i]); d_b_d = 8'(bv[i]); d_a_eol = 0; d_a_eof = 0; d_a_v = 1; d_b_v = 1;
      #1 chk(d_a_r, "R9 fill accepted", d_a_r, 1);
      @(posedge clk);
      @(negedge clk);
    end
    d_a_d = 8'(av[3]); d_b_d = 8'(bv[3]);
    #1 chk(!d_a_r && !d_b_r, "R9 no accept while stalled", d_a_r, 0);
    repeat (3) begin
      @(negedge clk);
      chk(d_o_v && d_o_d == 8'(ex[0]), "R9 output held", d_o_d, ex[0]);
      chk(!d_a_r, "R9 input blocked", d_a_r, 0);
    end
    @(negedge clk);
    d_o_r = 1;
    #1 chk(d_o_v && d_o_d == 8'(ex[0]), "R9 first after release", d_o_d, ex[0]);
    chk(d_a_r, "R9 accept on release", d_a_r, 1);
    @(posedge clk);
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      d_a_v = 0; d_b_v = 0;
      chk(d_o_v && d_o_d == 8'(ex[i]), "R9 drain in order", d_o_d, ex[i]);
    end
    @(negedge clk);
    chk(!d_o_v, "R9 drained", d_o_v, 0);
  endtask

  task automatic w_beat(input int s, input int seed);
    int lat;
    longint av [8];
    longint bv [8];
    longint e;
    for (int l = 0; l < 8; l++) begin
      av[l] = (l * 37 + seed) & 255;
      bv[l] = (l * 53 + 90 + seed) & 255;
    end
    av[0] = 255; bv[0] = 255;
    for (int l = 0; l < 8; l++) begin
      w_a_d[l*8 +: 8] = 8'(av[l]);
      w_b_d[l*8 +: 8] = 8'(bv[l]);
    end
    w_scale = 16'(s); w_a_v = 1; w_b_v = 1;
    @(posedge clk);
    @(negedge clk);
    w_a_v = 0; w_b_v = 0;
    lat = 1;
    while (!w_o_v && lat < 8) begin @(negedge clk); lat++; end
    chk(lat == 3, "R8 latency 8-lane", lat, 3);
    for (int l = 0; l < 8; l++) begin
      e = exp_c(av[l], bv[l], s, 1'b0, 1'b0);
      chk(longint'(w_o_d[l*8 +: 8]) == e, "R6 R4 lane wrap", longint'(w_o_d[l*8 +: 8]), e);
    end
    if (s == 16'h8000)
      chk(w_o_d[7:0] == 8'd1, "R4 255x255 wraps to 1", w_o_d[7:0], 1);
    @(negedge clk);
  endtask

  task automatic s_beat(input longint a0, b0, a1, b1, a2, b2, input int s);
    int lat;
    longint av [3];
    longint bv [3];
    longint e, act;
    av = '{a0, a1, a2};
    bv = '{b0, b1, b2};
    for (int c = 0; c < 3; c++) begin
      s_a_d[c*16 +: 16] = 16'(av[c]);
      s_b_d[c*16 +: 16] = 16'(bv[c]);
    end
    s_scale = 16'(s); s_a_v = 1; s_b_v = 1;
    @(posedge clk);
    @(negedge clk);
    s_a_v = 0; s_b_v = 0;
    lat = 1;
    while (!s_o_v && lat < 8) begin @(negedge clk); lat++; end
    chk(lat == 3, "R8 latency 3-channel", lat, 3);
    for (int c = 0; c < 3; c++) begin
      e = exp_c(av[c], bv[c], s, 1'b1, 1'b1);
      act = longint'($signed(s_o_d[c*16 +: 16]));
      chk(act == e, "R5 R3 signed channel", act, e);
    end
    @(negedge clk);
  endtask

  task automatic t_wide();
    w_beat(16'h8000, 200);
    w_beat(16'h6000, 3);
  endtask

  task automatic t_signed();
    s_beat(-32768, -32768, -200, 300, 181, 181, 16'h8000);
    s_beat(-3, 1, 100, -3, 181, 181, 16'h4000);
    s_beat(-32768, 32767, 32767, 32767, -1, -1, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_arith_u8();
    t_scale_per_beat();
    t_one_sided();
    t_stall();
    t_wide();
    t_signed();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule